// File: doc/BRIEF.md
# Priority Preemption Interrupt Controller

This block merges a set of software-raised flags and peripheral request lines into one interrupt request to a processor. Each source has its own 4-bit priority. A request reaches the processor only when a pending source outranks the current priority level, which software can read and write. The level works as a preemption threshold. A handler running at some level can only be interrupted by a source whose priority is strictly higher.

When the processor request rises, the number of the winning source is latched as the interrupt vector. The block accepts an acknowledge in one of two ways. In hardware vector mode the processor pulses a strobe and takes the vector from a dedicated output. In software mode the handler reads the acknowledge register. Either acknowledge saves the current level on a 16-entry last-in-first-out stack, raises the level to the winner's priority and drops the request. Any write to the end-of-interrupt register restores the saved level.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every source priority reads 0, the current level reads 15, and both irqReq and irqVec are 0.
- R2: irqReq is registered. It is 1 in the cycle after a clock edge at which some pending source had a priority strictly greater than the current level. Otherwise it is 0.
- R3: Source numbers 0 to NUM_SW-1 are the software flags, set by bit n of the flag register. Source NUM_SW+k is srcReq[k]. All sources compete in one arbitration: the highest priority wins, and on a tie the lowest source number wins.
- R4: The vector register loads the winner's number only at the edge where irqReq goes from 0 to 1. It holds that value while the source lines change, until the next such edge.
- R5: When hwVecEn is 1, irqVec equals the latched vector. When hwVecEn is 0, irqVec is 0.
- R6: With hwVecEn at 1, an acknowledge is an irqAck pulse. With hwVecEn at 0, an acknowledge is a bus read of address 1, and irqAck has no effect. An acknowledge while irqReq is 0 has no effect.
- R7: An acknowledge pushes the current level onto the stack. It then sets the level to the latched winner's priority, and irqReq is 0 in the following cycle.
- R8: Any write to address 2 pops the stack into the current level. When the stack is empty, the level is left unchanged.
- R9: The register map uses word addresses. Address 0 is the current level, in bits [3:0], read/write. Address 1 reads the latched vector. Address 3 holds the software flags. Addresses 4+n hold the priority of source n, in bits [3:0]. Unmapped addresses read 0.
- R10: If an acknowledge and an end-of-interrupt write happen in the same cycle, the acknowledge takes effect and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcReq | input | NUM_SRC-NUM_SW | Peripheral request lines, active high |
| hwVecEn | input | 1 | 1 selects hardware vector mode |
| irqAck | input | 1 | Acknowledge strobe from the processor (hardware vector mode) |
| busSel | input | 1 | Register access valid |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Word address |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data, combinational |
| irqReq | output | 1 | Interrupt request to the processor |
| irqVec | output | log2(NUM_SRC) | Vector driven to the processor |

## Verification
The arbitration is tried with sources whose priorities are all zero against a level of 15 and then against a level of 0. These two cases separate a strict comparison from a greater-or-equal one. A pair of sources with equal priority tests the tie order, and a software flag tied with a peripheral line shows that both kinds of source share one arbiter. A higher-priority source that arrives while a request is already pending shows that the vector is held rather than tracked. Its later assertion after an acknowledge shows nested preemption. Sequences of acknowledges and end-of-interrupt writes, including a pop on an empty stack, an acknowledge with no request, an irqAck in software mode and an acknowledge in the same cycle as an end-of-interrupt write, tell correct stack and priority handling apart from extra or missing pushes.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int PRIO_W   = 4;
  localparam int CPR_ADDR = 0;
  localparam int ACK_ADDR = 1;
  localparam int EOI_ADDR = 2;
  localparam int SWF_ADDR = 3;
  localparam int PSR_BASE = 4;

  typedef struct packed {
    logic push;    // acknowledge: save level, raise to winner priority
    logic pop;     // end of interrupt: restore level
    logic cprWr;   // software write of current level
    logic swfWr;   // software flag write
    logic prioWr;  // source priority write
    logic latch;   // load vector on request assertion
  } ctlStrobes_t;
endpackage

// File: rtl/pic_arbiter.sv
module pic_arbiter
  import pic_pkg::*;
#(
  parameter int NUM_SRC = 8,
  localparam int VEC_W = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]             pending,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prioTab,
  input  logic [PRIO_W-1:0]              floorPrio,
  output logic                           found,
  output logic [VEC_W-1:0]               winIdx,
  output logic [PRIO_W-1:0]              winPrio
);
  logic [PRIO_W-1:0] bestPrio;

  // Scan upward; a later source replaces the best only when strictly
  // higher, so ties stay with the lowest number and the floor is exclusive.
  always_comb begin
    bestPrio = floorPrio;
    winIdx   = '0;
    found    = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pending[i] && (prioTab[i] > bestPrio)) begin
        bestPrio = prioTab[i];
        winIdx   = VEC_W'(i);
        found    = 1'b1;
      end
    end
    winPrio = bestPrio;
  end
endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl
  import pic_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int ADDR_W  = 5,
  localparam int VEC_W  = $clog2(NUM_SRC)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hwVecEn,
  input  logic              irqAck,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              found,
  output ctlStrobes_t       strobes,
  output logic [VEC_W-1:0]  prioIdx,
  output logic              irqReq
);
  logic wrEn, rdEn, ackFire;
  int   addrInt;

  assign wrEn    = busSel & busWr;
  assign rdEn    = busSel & ~busWr;
  assign addrInt = int'(busAddr);

  // Acknowledge path depends on the vector mode; only valid with a live request.
  assign ackFire = irqReq & (hwVecEn ? irqAck : (rdEn && addrInt == ACK_ADDR));

  always_comb begin
    strobes        = '0;
    strobes.push   = ackFire;
    strobes.pop    = wrEn && addrInt == EOI_ADDR && !ackFire;
    strobes.cprWr  = wrEn && addrInt == CPR_ADDR && !ackFire;
    strobes.swfWr  = wrEn && addrInt == SWF_ADDR;
    strobes.prioWr = wrEn && addrInt >= PSR_BASE && addrInt < PSR_BASE + NUM_SRC;
    strobes.latch  = found && !ackFire && !irqReq;
    prioIdx        = VEC_W'(addrInt - PSR_BASE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) irqReq <= 1'b0;
    else       irqReq <= found & ~ackFire;
  end

  // R2
  rise_needs_winner_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqReq) |-> $past(found));
endmodule

// File: rtl/pic_datapath.sv
module pic_datapath
  import pic_pkg::*;
#(
  parameter int NUM_SRC     = 8,
  parameter int NUM_SW      = 2,
  parameter int STACK_DEPTH = 16,
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 32,
  localparam int VEC_W      = $clog2(NUM_SRC),
  localparam int NUM_HW     = NUM_SRC - NUM_SW,
  localparam int CNT_W      = $clog2(STACK_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [VEC_W-1:0]  prioIdx,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [NUM_HW-1:0] srcReq,
  output logic              found,
  output logic [VEC_W-1:0]  vecReg,
  output logic [DATA_W-1:0] busRdata
);
  logic [NUM_SRC-1:0][PRIO_W-1:0] prioTab;
  logic [NUM_SW-1:0]              swFlags;
  logic [PRIO_W-1:0]              curPrio, latPrio, winPrio;
  logic [VEC_W-1:0]               winIdx;
  logic [PRIO_W-1:0]              stackMem [STACK_DEPTH];
  logic [CNT_W-1:0]               depth;
  logic                           unusedWdata;
  int                             addrInt;

  assign unusedWdata = ^busWdata;
  assign addrInt     = int'(busAddr);

  genvar g;
  generate
    for (g = 0; g < NUM_SRC; g++) begin : gPrio
      always_ff @(posedge clk) begin
        if (!rstN) prioTab[g] <= '0;
        else if (strobes.prioWr && prioIdx == VEC_W'(g)) prioTab[g] <= busWdata[PRIO_W-1:0];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)              swFlags <= '0;
    else if (strobes.swfWr) swFlags <= busWdata[NUM_SW-1:0];
  end

  pic_arbiter #(.NUM_SRC(NUM_SRC)) uArb (
    .pending  ({srcReq, swFlags}),
    .prioTab  (prioTab),
    .floorPrio(curPrio),
    .found    (found),
    .winIdx   (winIdx),
    .winPrio  (winPrio)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecReg  <= '0;
      latPrio <= '0;
    end else if (strobes.latch) begin
      vecReg  <= winIdx;
      latPrio <= winPrio;
    end
  end

  // Current level with save/restore stack; acknowledge beats restore.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curPrio <= '1;
      depth   <= '0;
      for (int i = 0; i < STACK_DEPTH; i++) stackMem[i] <= '0;
    end else if (strobes.push) begin
      if (depth < CNT_W'(STACK_DEPTH)) begin
        stackMem[depth[CNT_W-1:0] % STACK_DEPTH] <= curPrio;
        depth <= depth + 1'b1;
      end
      curPrio <= latPrio;
    end else if (strobes.pop) begin
      if (depth != '0) begin
        curPrio <= stackMem[(depth - 1'b1) % STACK_DEPTH];
        depth   <= depth - 1'b1;
      end
    end else if (strobes.cprWr) begin
      curPrio <= busWdata[PRIO_W-1:0];
    end
  end

  always_comb begin
    busRdata = '0;
    if (addrInt == CPR_ADDR)      busRdata = DATA_W'(curPrio);
    else if (addrInt == ACK_ADDR) busRdata = DATA_W'(vecReg);
    else if (addrInt == SWF_ADDR) busRdata = DATA_W'(swFlags);
    else if (addrInt >= PSR_BASE && addrInt < PSR_BASE + NUM_SRC)
      busRdata = DATA_W'(prioTab[VEC_W'(addrInt - PSR_BASE)]);
  end

  // R4
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.latch |=> $stable(vecReg));
  // R8
  pop_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.pop && depth == '0) |=> $stable(curPrio));
  // R7
  push_depth_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.push && depth < CNT_W'(STACK_DEPTH)) |=> depth == $past(depth) + 1'b1);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int NUM_SRC     = 8,
  parameter int NUM_SW      = 2,
  parameter int STACK_DEPTH = 16,
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 32,
  localparam int VEC_W      = $clog2(NUM_SRC),
  localparam int NUM_HW     = NUM_SRC - NUM_SW
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_HW-1:0] srcReq,
  input  logic              hwVecEn,
  input  logic              irqAck,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqReq,
  output logic [VEC_W-1:0]  irqVec
);
  ctlStrobes_t      strobes;
  logic             found;
  logic [VEC_W-1:0] prioIdx, vecReg;

  pic_ctrl #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .hwVecEn(hwVecEn), .irqAck(irqAck),
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr), .found(found),
    .strobes(strobes), .prioIdx(prioIdx), .irqReq(irqReq)
  );

  pic_datapath #(
    .NUM_SRC(NUM_SRC), .NUM_SW(NUM_SW), .STACK_DEPTH(STACK_DEPTH),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .prioIdx(prioIdx),
    .busAddr(busAddr), .busWdata(busWdata), .srcReq(srcReq),
    .found(found), .vecReg(vecReg), .busRdata(busRdata)
  );

  assign irqVec = hwVecEn ? vecReg : '0;

  // R7
  hw_ack_drops_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hwVecEn && irqAck && irqReq) |=> !irqReq);
endmodule

// File: tb/tb_prio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_prio_irq_ctrl;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rstN;
  logic [5:0]        srcReq;
  logic              hwVecEn, irqAck, busSel, busWr;
  logic [ADDR_W-1:0] busAddr;
  logic [DATA_W-1:0] busWdata, busRdata;
  logic              irqReq;
  logic [2:0]        irqVec;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  typedef struct {
    string tag;
    bit    req;
    int    vec;
    bit    rdEn;
    int    rd;
  } item_t;
  item_t expQ[$];

  always #4 clk = ~clk;

  prio_irq_ctrl dut (
    .clk(clk), .rstN(rstN), .srcReq(srcReq), .hwVecEn(hwVecEn), .irqAck(irqAck),
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .irqReq(irqReq), .irqVec(irqVec)
  );

  // Monitor: compares at the falling edge, after the posedge that produced the result.
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      item_t it;
      it = expQ.pop_front();
      checks++;
      if (irqReq !== it.req || int'(irqVec) != it.vec ||
          (it.rdEn && int'(busRdata) != it.rd)) begin
        errors++;
        $display("FAIL %s: irqReq=%0b irqVec=%0d rdata=%0d expected irqReq=%0b irqVec=%0d rdata=%0d",
                 it.tag, irqReq, irqVec, busRdata, it.req, it.vec, it.rd);
      end
    end
  end

  task automatic busWrite(int addr, int data);
    busSel = 1; busWr = 1; busAddr = ADDR_W'(addr); busWdata = DATA_W'(data);
    @(posedge clk);
    @(negedge clk); #1;
    busSel = 0; busWr = 0;
  endtask

  // Driver: lets one edge pass, queues what the outputs must show after it.
  task automatic expectNext(string tag, bit req, int vec, bit rdEn, int addr, int rd);
    busSel = rdEn; busWr = 0; busAddr = ADDR_W'(addr);
    @(posedge clk);
    expQ.push_back('{tag, req, vec, rdEn, rd});
    @(negedge clk); #1;
    busSel = 0;
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finishRun();
    end
  end

  initial begin
    rstN = 0; srcReq = '0; hwVecEn = 1; irqAck = 0;
    busSel = 0; busWr = 0; busAddr = '0; busWdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    rstN = 1;

    expectNext("R1 reset level", 0, 0, 1, 0, 15);
    expectNext("R1 reset priority", 0, 0, 1, 7, 0);

    srcReq = 6'h3F;
    expectNext("R2 zero priority under level 15", 0, 0, 1, 0, 15);
    busWrite(0, 0);
    expectNext("R2 equal priority does not win", 0, 0, 1, 0, 0);

    srcReq = '0;
    busWrite(9, 3); busWrite(10, 3); busWrite(6, 7);
    expectNext("R9 priority readback", 0, 0, 1, 9, 3);
    srcReq = 6'b011000;
    expectNext("R3 tie goes to lowest source", 1, 5, 0, 0, 0);
    srcReq = 6'b011001;
    expectNext("R4 vector held with higher newcomer", 1, 5, 0, 0, 0);

    irqAck = 1;
    expectNext("R7 ack raises level, drops request", 0, 5, 1, 0, 3);
    irqAck = 0;
    expectNext("R4 new assertion reloads vector", 1, 2, 0, 0, 0);
    irqAck = 1;
    expectNext("R7 nested ack", 0, 2, 1, 0, 7);
    irqAck = 0;
    expectNext("R2 lower sources blocked by level", 0, 2, 1, 0, 7);

    srcReq = 6'b011000;
    busWrite(2, 0);
    expectNext("R8 pop restores level", 0, 2, 1, 0, 3);
    busWrite(2, 0);
    expectNext("R8 second pop re-enables source", 1, 5, 1, 0, 0);

    srcReq = '0;
    busWrite(0, 9);
    busWrite(2, 0);
    expectNext("R8 pop on empty stack keeps level", 0, 5, 1, 0, 9);

    hwVecEn = 0;
    busWrite(5, 12);
    busWrite(3, 2);
    expectNext("R5 software mode drives zero vector", 1, 0, 1, 3, 2);
    irqAck = 1;
    expectNext("R6 strobe ignored in software mode", 1, 0, 1, 0, 9);
    irqAck = 0;
    expectNext("R6 read of ack register acknowledges", 0, 0, 1, 1, 1);
    expectNext("R7 software ack raised level", 0, 0, 1, 0, 12);
    expectNext("R6 read without request", 0, 0, 1, 1, 1);
    busWrite(2, 0);
    expectNext("R6 only one level was saved", 1, 0, 1, 0, 9);
    busWrite(2, 0);
    expectNext("R8 empty stack after single push", 1, 0, 1, 0, 9);

    busWrite(3, 0);
    hwVecEn = 1;
    busWrite(4, 14); busWrite(11, 14);
    busWrite(3, 1);
    srcReq = 6'b100000;
    expectNext("R3 software flag ties peripheral", 1, 0, 1, 3, 1);
    expectNext("R5 hardware mode shows vector", 1, 0, 1, 1, 0);

    irqAck = 1;
    busWrite(2, 0);
    irqAck = 0;
    expectNext("R10 ack wins over same-cycle EOI", 0, 0, 1, 0, 14);
    busWrite(2, 0);
    expectNext("R10 saved level still on stack", 1, 0, 1, 0, 9);

    repeat (2) @(posedge clk);
    done = 1;
    finishRun();
  end
endmodule